// File: doc/BRIEF.md
# Precise Exception Flush Controller

This block is the exception control of a five-stage in-order pipeline. Stage indices are 0 = fetch, 1 = decode, 2 = execute, 3 = memory and 4 = writeback. Each stage reports whether it holds a live instruction. The first four stages can also report a fault, with a cause code and the program counter that the instruction has carried down the pipe. Writeback cannot fault.

When faults are reported, the controller picks the oldest one, which is the one in the highest-numbered stage. In the same cycle it raises flush bits that kill that instruction and every younger one. Instructions in later stages keep moving and retire.

The controller does not redirect fetch at detection time. It holds fetch flushed and waits until stages 1 to 4 hold no live instruction. Only then does it pulse `take_o`, which carries the captured PC and cause and tells fetch to go to the handler. The handler therefore sees the fault land exactly between two instructions.

An external interrupt is attached to the instruction in the decode stage. An older instruction that faults while the pipe drains replaces the captured fault. After the redirect, all fault reports are ignored until the handler's first instruction shows up valid in fetch.

Top module: `exc_flush_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after release (with no stage valid), `flush_o` is all zero and `take_o` is low.
- R2: When the controller is accepting faults, a stage counts as faulting if its valid bit and its fault bit are both 1. The highest-numbered faulting stage s among 0..3 wins. In that same cycle `flush_o` bits 0..s are 1.
- R3: In the detection cycle, flush bits of stages above s are 0. With no faulting stage, `flush_o` is all zero.
- R4: A fault bit on a stage whose valid bit is 0 has no effect on `flush_o` or on the captured fault.
- R5: After detection, `take_o` stays low while any of valid bits 1..4 is set. It rises in the first such cycle with all of them clear. It then presents the captured stage's PC and cause; the cause of stage k is bits [k*CAUSE_W +: CAUSE_W] and the PC is bits [k*PC_W +: PC_W].
- R6: From the cycle after detection up to and including the `take_o` cycle, `flush_o[0]` is 1 every cycle. During this drain a fault reported by stage 0 is ignored.
- R7: During the drain, a valid fault in stage 1..3 flushes stages 0..s at once. It replaces the captured PC and cause, and delays `take_o` accordingly.
- R8: `irq_i` with decode valid counts as a decode fault with cause `IRQ_CAUSE`. A real decode fault keeps its own cause. A fault in a later stage still wins. With decode invalid, `irq_i` has no effect.
- R9: After `take_o`, fault reports and `irq_i` are ignored (flush all zero) in every cycle where `stg_valid_i[0]` is 0. In the first cycle with `stg_valid_i[0]` set, faults are evaluated again as in R2.
- R10: `take_o` is a single-cycle pulse for each accepted fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_valid_i | input | NUM_STAGES | Live-instruction flag per stage, bit 0 = fetch |
| stg_exc_i | input | NUM_STAGES-1 | Fault flag for stages 0..3 |
| stg_cause_i | input | (NUM_STAGES-1)*CAUSE_W | Cause code per faultable stage |
| stg_pc_i | input | (NUM_STAGES-1)*PC_W | Instruction PC per faultable stage |
| irq_i | input | 1 | External interrupt request, level |
| flush_o | output | NUM_STAGES | Kill the instruction in each marked stage |
| take_o | output | 1 | Redirect fetch to the handler now |
| take_pc_o | output | PC_W | PC of the faulting instruction |
| take_cause_o | output | CAUSE_W | Cause of the taken fault |

## Verification
The checker watches, on every cycle, the stage-order properties of the outputs. The flush bits always form a contiguous run starting at fetch. A take only happens with stages 1 to 4 empty and always comes with a fetch flush. It is one cycle wide, and it is followed by a quiet flush vector until fetch turns valid. Which stage wins, the exact captured PC and cause, how an interrupt folds into the decode slot, and the replacement of a fault by an older one during the drain all depend on input history. These are shown by the bench: it sweeps every valid, fault and interrupt combination from the idle state and adds directed drain sequences.

// File: rtl/exc_flush_pkg.sv
package exc_flush_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_WAIT  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/exc_oldest_pick.sv
// Finds the highest-numbered set request (the oldest instruction).
module exc_oldest_pick #(
    parameter int N  = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/exc_flush_mask.sv
// Thermometer mask: stages 0..idx set when en is high.
module exc_flush_mask #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  mask
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        localparam logic [IW-1:0] GI = IW'(g);
        assign mask[g] = en && (GI <= idx);
    end
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl #(
    parameter int NUM_STAGES = 5,
    parameter int PC_W       = 32,
    parameter int CAUSE_W    = 5,
    parameter int IRQ_STAGE  = 1,
    parameter logic [CAUSE_W-1:0] IRQ_CAUSE = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_STAGES-1:0]             stg_valid_i,
    input  logic [NUM_STAGES-2:0]             stg_exc_i,
    input  logic [(NUM_STAGES-1)*CAUSE_W-1:0] stg_cause_i,
    input  logic [(NUM_STAGES-1)*PC_W-1:0]    stg_pc_i,
    input  logic                              irq_i,
    output logic [NUM_STAGES-1:0]             flush_o,
    output logic                              take_o,
    output logic [PC_W-1:0]                   take_pc_o,
    output logic [CAUSE_W-1:0]                take_cause_o
);
    import exc_flush_pkg::*;

    localparam int NEXC   = NUM_STAGES - 1;
    localparam int SIDX_W = $clog2(NUM_STAGES);

    typedef struct packed {
        ctl_state_e         state;
        logic [PC_W-1:0]    pc;
        logic [CAUSE_W-1:0] cause;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic [PC_W-1:0]    pc_arr    [NEXC];
    logic [CAUSE_W-1:0] cause_arr [NEXC];

    for (genvar k = 0; k < NEXC; k++) begin : g_unpack
        assign pc_arr[k]    = stg_pc_i[k*PC_W +: PC_W];
        assign cause_arr[k] = stg_cause_i[k*CAUSE_W +: CAUSE_W];
    end

    logic [NEXC-1:0]       req_sync, req_run, req_drain, req_sel;
    logic                  irq_hit, accept_run, in_drain, older_busy;
    logic                  hit;
    logic [SIDX_W-1:0]     hit_idx;
    logic [NUM_STAGES-1:0] kill_mask;
    logic                  take_now;

    always_comb begin
        req_sync   = stg_valid_i[NEXC-1:0] & stg_exc_i;
        irq_hit    = irq_i && stg_valid_i[IRQ_STAGE];
        req_run    = req_sync;
        req_run[IRQ_STAGE] = req_sync[IRQ_STAGE] | irq_hit;
        req_drain  = req_sync;
        req_drain[0] = 1'b0;
        accept_run = (r_q.state == ST_RUN) ||
                     ((r_q.state == ST_WAIT) && stg_valid_i[0]);
        in_drain   = (r_q.state == ST_DRAIN);
        if (accept_run)    req_sel = req_run;
        else if (in_drain) req_sel = req_drain;
        else               req_sel = '0;
    end

    exc_oldest_pick #(.N(NEXC), .IW(SIDX_W)) u_pick (
        .req (req_sel),
        .hit (hit),
        .idx (hit_idx)
    );

    exc_flush_mask #(.N(NUM_STAGES), .IW(SIDX_W)) u_mask (
        .en   (hit),
        .idx  (hit_idx),
        .mask (kill_mask)
    );

    always_comb begin
        older_busy = |stg_valid_i[NUM_STAGES-1:1];
        take_now   = in_drain && !hit && !older_busy;

        r_d = r_q;
        if (hit) begin
            r_d.state = ST_DRAIN;
            r_d.pc    = pc_arr[hit_idx];
            if ((int'(hit_idx) == IRQ_STAGE) && !req_sync[IRQ_STAGE])
                r_d.cause = IRQ_CAUSE;
            else
                r_d.cause = cause_arr[hit_idx];
        end else if (take_now) begin
            r_d.state = ST_WAIT;
        end else if ((r_q.state == ST_WAIT) && stg_valid_i[0]) begin
            r_d.state = ST_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_RUN;
            r_q.pc    <= '0;
            r_q.cause <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        flush_o    = kill_mask;
        flush_o[0] = kill_mask[0] | in_drain;
    end

    assign take_o       = take_now;
    assign take_pc_o    = r_q.pc;
    assign take_cause_o = r_q.cause;
endmodule

// File: rtl/exc_flush_ctrl_chk.sv
module exc_flush_ctrl_chk #(
    parameter int NUM_STAGES = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_STAGES-1:0] stg_valid_i,
    input logic [NUM_STAGES-1:0] flush_o,
    input logic                  take_o
);
    // R2
    flush_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flush_o >> 1) & ~flush_o) == '0);

    // R5
    take_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (stg_valid_i[NUM_STAGES-1:1] == '0));

    // R6
    take_kills_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> flush_o[0]);

    // R10
    take_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R9
    quiet_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (stg_valid_i[0] || (flush_o == '0)));
endmodule

bind exc_flush_ctrl exc_flush_ctrl_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stg_valid_i (stg_valid_i),
    .flush_o     (flush_o),
    .take_o      (take_o)
);

// File: tb/exc_flush_ctrl_tb.sv
module exc_flush_ctrl_tb;
    localparam int NS = 5;
    localparam int PW = 32;
    localparam int CW = 5;
    localparam logic [CW-1:0] IRQC = 5'd30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] valid = '0;
    logic [NS-2:0] exc = '0;
    logic          irq = 1'b0;
    logic [NS-1:0] flush;
    logic          take;
    logic [PW-1:0] tpc;
    logic [CW-1:0] tcause;

    // stage k: pc = 0x100*k + 4, cause = k + 1
    logic [(NS-1)*PW-1:0] pcs    = {32'h304, 32'h204, 32'h104, 32'h004};
    logic [(NS-1)*CW-1:0] causes = {5'd4, 5'd3, 5'd2, 5'd1};

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    exc_flush_ctrl #(.NUM_STAGES(NS), .PC_W(PW), .CAUSE_W(CW), .IRQ_CAUSE(IRQC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stg_valid_i  (valid),
        .stg_exc_i    (exc),
        .stg_cause_i  (causes),
        .stg_pc_i     (pcs),
        .irq_i        (irq),
        .flush_o      (flush),
        .take_o       (take),
        .take_pc_o    (tpc),
        .take_cause_o (tcause)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [NS-1:0] v, input logic [NS-2:0] x, input logic q);
        @(negedge clk);
        valid = v; exc = x; irq = q;
        #1;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(flush == '0, "R1 flush in reset", flush, 0);
        chk(!take, "R1 take in reset", take, 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(flush == '0 && !take, "R1 after release", {take, flush}, 0);

        // R2 R3 R4 R8: sweep every valid/fault/irq pattern from idle
        for (int c = 0; c < 1024; c++) begin
            logic [4:0] v;
            logic [3:0] x, e;
            logic q;
            int s;
            logic [4:0] m;
            logic [CW-1:0] ec;
            v = c[4:0]; x = c[8:5]; q = c[9];
            e = v[3:0] & x;
            if (q && v[1]) e[1] = 1'b1;
            s = -1;
            for (int k = 0; k < 4; k++) if (e[k]) s = k;
            m = (s < 0) ? 5'd0 : 5'((1 << (s + 1)) - 1);
            ec = (s == 1 && !(v[1] && x[1])) ? IRQC : CW'(s + 1);
            drive(v, x, q);
            chk(flush == m, "R2/R3 sweep flush mask", flush, m);
            chk(!take, "R4 no take at detection", take, 0);
            if (s >= 0) begin
                drive(5'b0, 4'b0, 1'b0);
                chk(take, "R5 take when empty", take, 1);
                chk(tpc == PW'(32'h100 * s + 4), "R5 take pc", tpc, 32'h100 * s + 4);
                chk(tcause == ec, "R8 take cause", tcause, ec);
                chk(flush[0], "R6 fetch flushed on take", flush, 1);
                drive(5'b11110, 4'b1111, 1'b1);
                chk(flush == '0 && !take, "R9 R10 ignored while waiting", {take, flush}, 0);
                drive(5'b00001, 4'b0000, 1'b0);
                chk(flush == '0 && !take, "R9 handler entry", {take, flush}, 0);
            end
        end

        // R5: decode fault, older instructions drain for three cycles
        drive(5'b11110, 4'b0010, 1'b0);
        chk(flush == 5'b00011, "R2 decode fault", flush, 5'b00011);
        drive(5'b11000, 4'b0000, 1'b0);
        chk(!take && flush == 5'b00001, "R5 R6 drain 1", {take, flush}, 5'b00001);
        drive(5'b10000, 4'b0000, 1'b0);
        chk(!take, "R5 drain 2", take, 0);
        drive(5'b00000, 4'b0000, 1'b0);
        chk(take && tpc == 32'h104 && tcause == 5'd2, "R5 take decode", {take, tpc}, {1'b1, 32'h104});
        drive(5'b00001, 4'b0000, 1'b0);

        // R7: older fault in memory during drain replaces decode fault
        drive(5'b00110, 4'b0010, 1'b0);
        chk(flush == 5'b00011, "R7 first detection", flush, 5'b00011);
        drive(5'b01001, 4'b1001, 1'b0);
        chk(flush == 5'b01111 && !take, "R7 older fault flush", {take, flush}, 5'b01111);
        drive(5'b10001, 4'b0001, 1'b0);
        chk(flush == 5'b00001 && !take, "R6 fetch fault ignored in drain", {take, flush}, 5'b00001);
        drive(5'b00000, 4'b0000, 1'b0);
        chk(take && tpc == 32'h304 && tcause == 5'd4, "R7 replaced fault taken", tpc, 32'h304);

        // R9: handler fetch itself faults in its entry cycle
        drive(5'b00001, 4'b0001, 1'b0);
        chk(flush == 5'b00001, "R9 entry-cycle fault evaluated", flush, 5'b00001);
        drive(5'b00000, 4'b0000, 1'b0);
        chk(take && tpc == 32'h004 && tcause == 5'd1, "R9 handler fetch fault taken", tpc, 32'h004);
        drive(5'b00001, 4'b0000, 1'b0);

        // R8: irq with decode invalid is ignored
        drive(5'b11101, 4'b0000, 1'b1);
        chk(flush == '0, "R8 irq without decode", flush, 0);
        drive(5'b00000, 4'b0000, 1'b0);
        chk(!take, "R8 no take", take, 0);

        summary();
    end
endmodule